// File: doc/BRIEF.md
# Three-Channel Compare-Match Periodic Timer

This block holds three independent 16-bit up-counters behind a small synchronous register bus. Each channel takes its count ticks from its own prescaler, compares the counter against a compare-A value, raises a sticky match flag, and can restart from zero on that match to form a periodic tick source. A level interrupt per channel is asserted while the flag and its enable are both set.

Software runs or halts every channel through one shared byte register, one bit per channel. The channel registers sit in three address windows of the same layout. The counter and the compare value are halfword registers. Everything else is a byte register on data bits 7:0. A flag is cleared by a two-step handshake: software first reads the status register while the flag is set, then writes 0 to that bit.

Top module: `trio_cmp_timer`

## Requirements
- R1: The shared run register sits at address 0x280. Bit n (n = 0..2) set to 1 runs channel n and cleared to 0 halts it. Bits 2:0 read back, and upper bits read as 0. The channel windows begin at 0x300 (channel 0), 0x380 (channel 1) and 0x000 (channel 2).
- R2: A read request (bus_req=1, bus_we=0) returns data on bus_rdata with bus_rvalid=1 on the cycle after it. Byte registers return their value zero-extended to 16 bits.
- R3: A running channel adds one to its counter (window offset 6, 16 bits) on each prescaled tick, and wraps from 0xFFFF to 0x0000.
- R4: Control bits 2:0 pick the prescaler. Code 0 gives every clock, 1 gives every 4th, 2 every 16th and 3 every 64th. Code 6 gives every 256th on channel 1 only, and code 7 every 1024th on channel 2 only. Every other code gives every clock. The prescaler phase restarts whenever the channel's run bit is 0.
- R5: A halted channel keeps its counter value. Running one channel leaves the counters of the others unchanged.
- R6: Control bits 7:5 pick the clear source. Code 1 returns the counter to 0 on a matching tick instead of adding one. Code 0 and every other code never clear it.
- R7: Status bit 0 (window offset 5) is set on a tick where the counter equals compare A (offset 8, 16 bits). It is not set before such a tick.
- R8: Status bit 0 clears only on a write with bit 0 = 0 that follows a read of the status register which returned the flag set. A write of 1, or a write of 0 with no such earlier read, leaves the flag set.
- R9: irq[n] is 1 exactly when channel n's flag is 1 and its interrupt-enable bit 0 (offset 4) is 1.
- R10: After reset the run bits are 0, the counters are 0, compare A is 0xFFFF, the flags are 0 and irq is 0.
- R11: Control (offset 0), mode (offset 1), I/O control (offset 2) and interrupt enable (offset 4) read back the byte last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Register access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address |
| bus_wdata | input | 16 | Write data (bits 7:0 for byte registers) |
| bus_rdata | output | 16 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data is valid this cycle |
| irq | output | 3 | Per-channel level interrupt |

## Verification
A wrong prescaler phase or divide code shows up as a counter value off by one or more ticks when it is read after a run of known length. Divide-by-1024 errors need about a thousand clocks to show. A lost or early compare match shows on the status read and on irq within one tick of the expected match. A broken clear handshake leaves the flag set, or drops it too early, on the very next status read. A stray write or a stray tick into the wrong window shows as a changed counter on a channel that was halted.

// File: rtl/trio_tmr_pkg.sv
package trio_tmr_pkg;
  localparam int NCH   = 3;
  localparam int AW    = 10;
  localparam int CW    = 16;
  localparam int PRE_W = 10;

  localparam logic [AW-1:0] RUN_ADDR = 10'h280;

  localparam logic [6:0] OFF_CTRL = 7'd0;
  localparam logic [6:0] OFF_MODE = 7'd1;
  localparam logic [6:0] OFF_IOC  = 7'd2;
  localparam logic [6:0] OFF_IEN  = 7'd4;
  localparam logic [6:0] OFF_STAT = 7'd5;
  localparam logic [6:0] OFF_CNT  = 7'd6;
  localparam logic [6:0] OFF_CMPA = 7'd8;

  localparam logic [2:0] CLR_ON_CMPA = 3'd1;

  // upper address bits of each channel window
  function automatic logic [2:0] win_tag(int ch);
    case (ch)
      0:       return 3'b110;
      1:       return 3'b111;
      default: return 3'b000;
    endcase
  endfunction

  function automatic int unsigned div_for(int ch, logic [2:0] code);
    case (code)
      3'd1:    return 4;
      3'd2:    return 16;
      3'd3:    return 64;
      3'd6:    return (ch == 1) ? 256 : 1;
      3'd7:    return (ch == 2) ? 1024 : 1;
      default: return 1;
    endcase
  endfunction
endpackage

// File: rtl/trio_tmr_prescale.sv
module trio_tmr_prescale
  import trio_tmr_pkg::*;
#(
  parameter int CH = 0,
  parameter int W  = PRE_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [2:0] code,
  output logic       tick
);
  logic [W-1:0] phase;
  logic [W-1:0] limit;

  assign limit = W'(div_for(CH, code) - 1);
  assign tick  = run && (phase >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n)              phase <= '0;
    else if (!run || tick)   phase <= '0;
    else                     phase <= phase + 1'b1;
  end
endmodule

// File: rtl/trio_tmr_chan.sv
module trio_tmr_chan
  import trio_tmr_pkg::*;
#(
  parameter int CH = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [6:0]    offs,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic [CW-1:0] cnt_o,
  output logic          flag_o,
  output logic          irq_o,
  output logic          wr_cnt_o,
  output logic          wr_stat_o
);
  logic [7:0]    ctrl, mode, ioc, ien;
  logic [CW-1:0] cnt, cmpa;
  logic          flag, armed, tick, match;

  trio_tmr_prescale #(.CH(CH), .W(PRE_W)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .code (ctrl[2:0]),
    .tick (tick)
  );

  assign wr_cnt_o  = wr_en && (offs == OFF_CNT);
  assign wr_stat_o = wr_en && (offs == OFF_STAT);
  assign match     = tick && (cnt == cmpa);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0; mode <= '0; ioc <= '0; ien <= '0;
      cmpa <= '1;
    end else if (wr_en) begin
      case (offs)
        OFF_CTRL: ctrl <= wdata[7:0];
        OFF_MODE: mode <= wdata[7:0];
        OFF_IOC:  ioc  <= wdata[7:0];
        OFF_IEN:  ien  <= wdata[7:0];
        OFF_CMPA: cmpa <= wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (wr_cnt_o) cnt <= wdata;
    else if (tick) begin
      if (cnt == cmpa && ctrl[7:5] == CLR_ON_CMPA) cnt <= '0;
      else                                         cnt <= cnt + 1'b1;
    end
  end

  // flag clear needs an earlier status read that saw it set
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (match) flag <= 1'b1;
      else if (wr_stat_o && armed && !wdata[0]) flag <= 1'b0;
      if (rd_en && offs == OFF_STAT) armed <= flag;
      else if (wr_stat_o)            armed <= 1'b0;
    end
  end

  always_comb begin
    case (offs)
      OFF_CTRL: rdata = {8'h00, ctrl};
      OFF_MODE: rdata = {8'h00, mode};
      OFF_IOC:  rdata = {8'h00, ioc};
      OFF_IEN:  rdata = {8'h00, ien};
      OFF_STAT: rdata = {15'h0000, flag};
      OFF_CNT:  rdata = cnt;
      OFF_CMPA: rdata = cmpa;
      default:  rdata = '0;
    endcase
  end

  assign cnt_o  = cnt;
  assign flag_o = flag;
  assign irq_o  = flag && ien[0];
endmodule

// File: rtl/trio_cmp_timer.sv
module trio_cmp_timer
  import trio_tmr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  output logic          bus_rvalid,
  output logic [NCH-1:0] irq
);
  logic [NCH-1:0]         run;
  logic [NCH-1:0]         hit, flag, wr_cnt, wr_stat;
  logic [NCH-1:0][CW-1:0] ch_rd, cnt_all;
  logic                   run_hit;
  logic [CW-1:0]          rd_mux;

  assign run_hit = bus_req && (bus_addr == RUN_ADDR);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign hit[i] = bus_req && (bus_addr[AW-1:7] == win_tag(i));
    trio_tmr_chan #(.CH(i)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run[i]),
      .wr_en    (hit[i] && bus_we),
      .rd_en    (hit[i] && !bus_we),
      .offs     (bus_addr[6:0]),
      .wdata    (bus_wdata),
      .rdata    (ch_rd[i]),
      .cnt_o    (cnt_all[i]),
      .flag_o   (flag[i]),
      .irq_o    (irq[i]),
      .wr_cnt_o (wr_cnt[i]),
      .wr_stat_o(wr_stat[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                run <= '0;
    else if (run_hit && bus_we) run <= bus_wdata[NCH-1:0];
  end

  always_comb begin
    rd_mux = '0;
    if (run_hit) rd_mux = CW'(run);
    for (int i = 0; i < NCH; i++)
      if (hit[i]) rd_mux = ch_rd[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_req && !bus_we;
      if (bus_req && !bus_we) bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/trio_cmp_timer_chk.sv
module trio_cmp_timer_chk
  import trio_tmr_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_req,
  input logic                   bus_we,
  input logic                   bus_rvalid,
  input logic [NCH-1:0]         run,
  input logic [NCH-1:0]         flag,
  input logic [NCH-1:0]         irq,
  input logic [NCH-1:0]         wr_cnt,
  input logic [NCH-1:0]         wr_stat,
  input logic [NCH-1:0][CW-1:0] cnt_all
);
  assert_rvalid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we) |=> bus_rvalid);

  for (genvar i = 0; i < NCH; i++) begin : g_a
    assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run[i] && !wr_cnt[i]) |=> (cnt_all[i] == $past(cnt_all[i]) ||
        cnt_all[i] == $past(cnt_all[i]) + 16'd1 || cnt_all[i] == 16'd0));
    assert_halt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!run[i] && !wr_cnt[i]) |=> $stable(cnt_all[i]));
    assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag[i]) |-> $past(wr_stat[i]));
    assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |-> flag[i]);
  end
endmodule

bind trio_cmp_timer trio_cmp_timer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_req   (bus_req),
  .bus_we    (bus_we),
  .bus_rvalid(bus_rvalid),
  .run       (run),
  .flag      (flag),
  .irq       (irq),
  .wr_cnt    (wr_cnt),
  .wr_stat   (wr_stat),
  .cnt_all   (cnt_all)
);

// File: tb/trio_cmp_timer_bench.sv
module trio_cmp_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_we = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        bus_rvalid;
  logic [2:0]  irq;
  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  trio_cmp_timer u_trio_cmp_timer (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq(irq)
  );

  localparam logic [9:0] RUNR = 10'h280;
  localparam logic [9:0] BASE [3] = '{10'h300, 10'h380, 10'h000};

  // table: channel, prescale code, edges counted while running, expected count (R4)
  localparam int NV = 10;
  localparam int V_CH   [NV] = '{0, 0,  0,  0,   1,   2,  0, 1, 2,  1};
  localparam int V_CODE [NV] = '{0, 1,  2,  3,   6,   7,  7, 5, 6,  1};
  localparam int V_EDGE [NV] = '{10,20, 40, 200, 600, 2100,10,7, 9,  13};
  localparam int V_EXP  [NV] = '{10,5,  2,  3,   2,   2,  10,7, 9,  3};

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_req = 0;
    if (!bus_rvalid) begin
      tests++; fails++;
      $display("FAIL R2 actual rvalid=0 expected=1");
    end
    d = bus_rdata;
  endtask

  // run mask for exactly n clock edges, then halt
  task automatic run_for(input logic [2:0] mask, input int n);
    wr(RUNR, {13'b0, mask});
    repeat (n - 2) @(negedge clk);
    wr(RUNR, 16'h0);
  endtask

  task automatic clear_flag(input int ch);
    logic [15:0] d;
    rd(BASE[ch] + 10'd5, d);
    wr(BASE[ch] + 10'd5, 16'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R10 reset state
    chk("R10 irq", int'(irq), 0);
    rd(RUNR, d);            chk("R10 run reg", d, 0);
    rd(BASE[0] + 10'd6, d); chk("R10 counter", d, 0);
    rd(BASE[1] + 10'd8, d); chk("R10 compare A", d, 16'hFFFF);
    rd(BASE[2] + 10'd5, d); chk("R10 status", d, 0);

    // R4 R3 prescaler table
    for (int k = 0; k < NV; k++) begin
      wr(BASE[V_CH[k]] + 10'd0, 16'(V_CODE[k]));
      wr(BASE[V_CH[k]] + 10'd6, 16'h0);
      run_for(3'(1 << V_CH[k]), V_EDGE[k]);
      rd(BASE[V_CH[k]] + 10'd6, d);
      chk($sformatf("R4 vec%0d count", k), d, V_EXP[k]);
    end

    // R1 run register decode and readback
    wr(RUNR, 16'hFFFD);
    rd(RUNR, d); chk("R1 run readback", d, 16'h0005);
    wr(RUNR, 16'h0);

    // R5 independence of halted channel
    wr(BASE[1] + 10'd6, 16'h1234);
    wr(BASE[0] + 10'd0, 16'h0);
    run_for(3'b001, 8);
    rd(BASE[1] + 10'd6, d); chk("R5 halted counter kept", d, 16'h1234);

    // R3 wrap
    wr(BASE[0] + 10'd8, 16'h0010);
    wr(BASE[0] + 10'd6, 16'hFFFE);
    run_for(3'b001, 3);
    rd(BASE[0] + 10'd6, d); chk("R3 wrap", d, 16'h0001);

    // R7 flag boundary: compare 3, no flag after 3 ticks, flag on 4th
    wr(BASE[0] + 10'd8, 16'd3);
    wr(BASE[0] + 10'd6, 16'd0);
    run_for(3'b001, 3);
    rd(BASE[0] + 10'd5, d); chk("R7 no flag before match", d, 0);
    run_for(3'b001, 1 + 2);
    rd(BASE[0] + 10'd5, d); chk("R7 flag on match tick", d, 1);
    clear_flag(0);

    // R6 clear on compare A: compare 4, 12 edges -> 12 mod 5
    wr(BASE[0] + 10'd0, 16'h0020);
    wr(BASE[0] + 10'd8, 16'd4);
    wr(BASE[0] + 10'd6, 16'd0);
    run_for(3'b001, 12);
    rd(BASE[0] + 10'd6, d); chk("R6 clear on compare", d, 2);

    // R9 irq gating, R8 clear handshake (no status read yet)
    chk("R9 irq masked", int'(irq), 0);
    wr(BASE[0] + 10'd4, 16'h0001);
    chk("R9 irq enabled", int'(irq), 1);
    wr(BASE[0] + 10'd5, 16'h0);
    rd(BASE[0] + 10'd5, d); chk("R8 write without read keeps", d, 1);
    wr(BASE[0] + 10'd5, 16'h0001);
    rd(BASE[0] + 10'd5, d); chk("R8 write one keeps", d, 1);
    wr(BASE[0] + 10'd5, 16'h0);
    rd(BASE[0] + 10'd5, d); chk("R8 read then zero clears", d, 0);
    chk("R9 irq drops", int'(irq), 0);

    // R6 never clear (code 0) and unsupported code 2
    wr(BASE[0] + 10'd0, 16'h0000);
    wr(BASE[0] + 10'd6, 16'd0);
    run_for(3'b001, 12);
    rd(BASE[0] + 10'd6, d); chk("R6 no clear", d, 12);
    clear_flag(0);
    wr(BASE[0] + 10'd0, 16'h0040);
    wr(BASE[0] + 10'd6, 16'd0);
    run_for(3'b001, 12);
    rd(BASE[0] + 10'd6, d); chk("R6 other code no clear", d, 12);

    // R11 readback on channel 2 window
    wr(BASE[2] + 10'd0, 16'h0023);
    wr(BASE[2] + 10'd1, 16'h0000);
    wr(BASE[2] + 10'd2, 16'h005A);
    wr(BASE[2] + 10'd4, 16'h0081);
    rd(BASE[2] + 10'd0, d); chk("R11 control", d, 16'h0023);
    rd(BASE[2] + 10'd1, d); chk("R11 mode", d, 16'h0000);
    rd(BASE[2] + 10'd2, d); chk("R11 io control", d, 16'h005A);
    rd(BASE[2] + 10'd4, d); chk("R11 enable", d, 16'h0081);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule